// File: doc/BRIEF.md
# Inverse-Sinc Preemphasis FIR Filter

This block is a fixed-point, linear-phase FIR filter placed ahead of a video DAC. It lifts the upper part of the passband to offset the sin(x)/x droop of the converter's zero-order hold. The default build has 21 taps for a 27 MHz sample stream with the passband reaching to 7.2 MHz. One signed sample is taken in on every clock in which the enable is high. The coefficients are passed in as a parameter and are never computed inside the block.

The impulse response is even-symmetric. Each pair of mirrored delay-line taps is added together before any multiplication. This leaves one multiplier per unique coefficient, which is 11 for 21 taps. The products are held in a register and summed at full precision. The result is then reduced to the output format by discarding the low fraction bits (floor rounding) and keeping the low word bits (two's-complement wrap). The output is wider than the input by a gain-margin parameter, so that the peaking gain fits.

Top module: `isinc_fir`

## Requirements
- R1: While `rst` is high at a clock edge, every delay-line, product and output register is cleared, whatever `en` is. After that edge `y_out` reads 0, and the outputs that follow are computed as if every earlier sample were 0.
- R2: A sample presented with `en` high at enabled edge k is first reflected in `y_out` just after enabled edge k+2. The latency is exactly two samples.
- R3: Coefficient parameter element j (bits j*16 upward, j = 0..10) is the weight of taps j and 20−j. Element 10 weights the centre tap alone. An impulse therefore produces the 21 coefficients in symmetric order.
- R4: With the input in signed Q0.9 and the coefficients in signed Q1.15, the output is floor(Σ h[t]·x[n−t] / 2^15). This is the exact sum with its low 15 bits discarded, rounded toward minus infinity. A 1-LSB impulse thus gives −1 wherever the coefficient is negative.
- R5: When the floored sum falls outside the output range, the output is its low OUT_W bits read as two's complement. The output wraps and does not saturate.
- R6: While `en` is low, no register changes. `y_out` holds, and input presented during that time has no effect on later outputs.
- R7: Internal arithmetic never overflows. Full-scale inputs of −512 and +511 held steady give the exact floored DC result.
- R8: The output is 10+GBITS bits wide with 9 fraction bits (default GBITS=1, 11 bits), so a result of −513 is representable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high clear of all registers |
| en | input | 1 | Sample enable; advances delay line and pipeline |
| x_in | input | 10 | Signed input sample, 9 fraction bits |
| y_out | output | 10+GBITS | Registered signed output, 9 fraction bits |

## Verification
A mixed table of sample values exercises the general sum. A half-scale impulse reads out every coefficient in symmetric tap order and fixes the two-sample latency. A one-LSB impulse tells floor rounding apart from truncation toward zero. Held full-scale negative and positive inputs confirm full internal precision. A second instance with a 10-bit output shows that the output wraps rather than saturates. Stretches with the enable low and a reset in mid-stream then check that new input is ignored and that the filter history is cleared.

// File: rtl/isinc_pkg.sv
package isinc_pkg;

  localparam int DEF_TAPS   = 21;
  localparam int DEF_COEF_W = 16;
  localparam int DEF_NUNIQ  = (DEF_TAPS + 1) / 2;

  // Unique coefficients, Q1.15; element 0 (LSBs) is the outermost tap,
  // the last element (MSBs) is the centre tap.
  localparam logic [DEF_NUNIQ*DEF_COEF_W-1:0] DEF_COEFS = {
    16'sd26600, 16'sd4700, -16'sd2550, 16'sd1450, -16'sd700, 16'sd250,
    16'sd0, -16'sd110, 16'sd130, -16'sd95, 16'sd40
  };

endpackage

// File: rtl/isinc_delay_line.sv
module isinc_delay_line #(
  parameter int TAPS = 21,
  parameter int W    = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [W-1:0]          din,
  output logic [TAPS-1:0][W-1:0] taps
);

  always_ff @(posedge clk) begin
    if (rst) begin
      taps <= '0;
    end else if (en) begin
      taps[0] <= din;
      for (int i = 1; i < TAPS; i++) taps[i] <= taps[i-1];
    end
  end

  // R2: each enabled edge moves the line by exactly one position
  a_r2_line_shift: assert property (@(posedge clk) disable iff (rst)
    en |=> taps[1] == $past(taps[0]));

  // R6: disabled cycles leave the line untouched
  a_r6_line_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(taps));

  // R1: reset empties the line
  a_r1_line_clear: assert property (@(posedge clk)
    rst |=> taps == '0);

endmodule

// File: rtl/isinc_fold_mac.sv
module isinc_fold_mac #(
  parameter int TAPS   = 21,
  parameter int IN_W   = 10,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 31,
  parameter logic [((TAPS+1)/2)*COEF_W-1:0] COEFS = '0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic [TAPS-1:0][IN_W-1:0] taps,
  output logic signed [ACC_W-1:0]   acc
);

  localparam int NUNIQ  = (TAPS + 1) / 2;
  localparam int SUM_W  = IN_W + 1;
  localparam int PROD_W = SUM_W + COEF_W;
  localparam bit ODD    = (TAPS % 2) == 1;

  logic signed [PROD_W-1:0] prod_q [NUNIQ];

  for (genvar k = 0; k < NUNIQ; k++) begin : g_fold
    logic signed [SUM_W-1:0]  pre;
    logic signed [COEF_W-1:0] coef;

    assign coef = COEFS[k*COEF_W +: COEF_W];

    if (ODD && (k == NUNIQ - 1)) begin : g_centre
      assign pre = {taps[k][IN_W-1], taps[k]};
    end else begin : g_pair
      assign pre = {taps[k][IN_W-1], taps[k]}
                 + {taps[TAPS-1-k][IN_W-1], taps[TAPS-1-k]};
    end

    always_ff @(posedge clk) begin
      if (rst)     prod_q[k] <= '0;
      else if (en) prod_q[k] <= pre * coef;
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NUNIQ; k++)
      acc = acc + {{(ACC_W-PROD_W){prod_q[k][PROD_W-1]}}, prod_q[k]};
  end

  // R1: cleared products give a zero sum
  a_r1_mac_clear: assert property (@(posedge clk)
    rst |=> acc == '0);

  // R6: sum frozen while disabled
  a_r6_mac_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc));

endmodule

// File: rtl/isinc_out_quant.sv
module isinc_out_quant #(
  parameter int ACC_W = 31,
  parameter int SHIFT = 15,
  parameter int OUT_W = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] acc,
  output logic signed [OUT_W-1:0] y
);

  logic [ACC_W-1:0] acc_u;
  assign acc_u = acc;

  // Dropping low bits floors; keeping low word bits wraps.
  always_ff @(posedge clk) begin
    if (rst)     y <= '0;
    else if (en) y <= acc_u[SHIFT +: OUT_W];
  end

  // R6: output register holds while disabled
  a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(y));

endmodule

// File: rtl/isinc_fir.sv
module isinc_fir #(
  parameter int TAPS      = 21,
  parameter int IN_W      = 10,
  parameter int IN_FRAC   = 9,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 15,
  parameter int GBITS     = 1,
  parameter logic [((TAPS+1)/2)*COEF_W-1:0] COEFS = isinc_pkg::DEF_COEFS
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en,
  input  logic signed [IN_W-1:0]       x_in,
  output logic signed [IN_W+GBITS-1:0] y_out
);

  localparam int NUNIQ    = (TAPS + 1) / 2;
  localparam int GROWTH   = $clog2(NUNIQ);
  localparam int ACC_W    = IN_W + 1 + COEF_W + GROWTH;
  localparam int OUT_W    = IN_W + GBITS;
  localparam int OUT_FRAC = IN_FRAC;
  localparam int SHIFT    = COEF_FRAC + IN_FRAC - OUT_FRAC;

  logic [TAPS-1:0][IN_W-1:0] taps;
  logic signed [ACC_W-1:0]   acc;

  isinc_delay_line #(.TAPS(TAPS), .W(IN_W)) u_line (
    .clk(clk), .rst(rst), .en(en), .din(x_in), .taps(taps)
  );

  isinc_fold_mac #(
    .TAPS(TAPS), .IN_W(IN_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .COEFS(COEFS)
  ) u_mac (
    .clk(clk), .rst(rst), .en(en), .taps(taps), .acc(acc)
  );

  isinc_out_quant #(.ACC_W(ACC_W), .SHIFT(SHIFT), .OUT_W(OUT_W)) u_quant (
    .clk(clk), .rst(rst), .en(en), .acc(acc), .y(y_out)
  );

  // R1: output reads zero right after a reset edge
  a_r1_reset_out: assert property (@(posedge clk)
    rst |=> y_out == '0);

  // R6: output port holds while disabled
  a_r6_port_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(y_out));

endmodule

// File: tb/sim_isinc_fir.sv
module sim_isinc_fir;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [9:0]  x = '0;
  logic signed [10:0] y0;
  logic signed [9:0]  y1;

  always #5 clk = ~clk;

  isinc_fir u0 (.clk(clk), .rst(rst), .en(en), .x_in(x), .y_out(y0));
  isinc_fir #(.GBITS(0)) u1 (.clk(clk), .rst(rst), .en(en), .x_in(x), .y_out(y1));

  // Requirement data: unique coefficients, element j weights taps j and 20-j
  localparam int C [11] = '{40, -95, 130, -110, 0, 250, -700, 1450, -2550, 4700, 26600};

  localparam int NSTIM = 24;
  localparam logic signed [9:0] STIM [NSTIM] = '{
    10'sd0, 10'sd100, -10'sd200, 10'sd511, -10'sd512, 10'sd37, -10'sd1, 10'sd1,
    10'sd250, -10'sd250, 10'sd300, -10'sd300, 10'sd0, 10'sd0, 10'sd480, 10'sd480,
    10'sd480, -10'sd100, -10'sd100, 10'sd60, -10'sd60, 10'sd200, 10'sd15, -10'sd15
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  longint hist [21];
  longint e0 [3];
  longint e1 [3];

  function automatic longint wrapw(longint v, int w);
    longint m;
    m = v & ((64'sd1 <<< w) - 1);
    if (m >= (64'sd1 <<< (w - 1))) m = m - (64'sd1 <<< w);
    return m;
  endfunction

  function automatic longint floored();
    longint s = 0;
    for (int t = 0; t < 21; t++) s += longint'(C[(t <= 10) ? t : 20 - t]) * hist[t];
    return s >>> 15;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int t = 0; t < 21; t++) hist[t] = 0;
    for (int i = 0; i < 3; i++) begin e0[i] = 0; e1[i] = 0; end
  endtask

  task automatic step(input logic signed [9:0] v, input string req);
    longint f;
    @(negedge clk); x = v; en = 1'b1;
    @(posedge clk); #2;
    for (int t = 20; t > 0; t--) hist[t] = hist[t-1];
    hist[0] = v;
    f = floored();
    e0[2] = e0[1]; e0[1] = e0[0]; e0[0] = wrapw(f, 11);
    e1[2] = e1[1]; e1[1] = e1[0]; e1[0] = wrapw(f, 10);
    chk(req, y0, e0[2]);
    chk(req, y1, e1[2]);
  endtask

  task automatic hold_step(input logic signed [9:0] v);
    @(negedge clk); x = v; en = 1'b0;
    @(posedge clk); #2;
    chk("R6 hold", y0, e0[2]);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset out", y0, 0);
    @(negedge clk); rst = 1'b0;

    // table walk: R4 general sum, R2 latency on every sample
    for (int i = 0; i < NSTIM; i++) step(STIM[i], "R4 table");
    for (int i = 0; i < 21; i++) step(10'sd0, "R4 flush");

    // R3: half-scale impulse reads out the coefficients; first outputs fix R2
    step(10'sd256, "R2 impulse");
    step(10'sd0, "R2 impulse");
    for (int i = 0; i < 22; i++) step(10'sd0, "R3 impulse");

    // R4: 1-LSB impulse, negative coefficients floor to -1
    step(10'sd1, "R4 lsb");
    for (int i = 0; i < 23; i++) step(10'sd0, "R4 lsb floor");

    // R7/R8 on u0 (-513), R5 wrap on u1 (511)
    for (int i = 0; i < 25; i++) step(-10'sd512, "R5 R7 R8 neg full");
    chk("R8 width", y0, -513);
    chk("R5 wrap", y1, 511);
    for (int i = 0; i < 25; i++) step(10'sd511, "R7 pos full");
    chk("R7 pos dc", y0, 511);

    // R6: enable low, changing input is ignored
    for (int i = 0; i < 6; i++) step(STIM[i+2], "R4 pre-hold");
    for (int i = 0; i < 5; i++) hold_step(10'sd333 - 10'(i * 97));
    for (int i = 0; i < 24; i++) step(STIM[(i*5) % NSTIM], "R6 resume");

    // R1: mid-stream reset with enable and data active
    @(negedge clk); rst = 1'b1; en = 1'b1; x = 10'sd77;
    @(posedge clk); #2;
    clear_model();
    chk("R1 mid reset", y0, 0);
    @(negedge clk); rst = 1'b0; en = 1'b0;
    for (int i = 0; i < 24; i++) step(STIM[NSTIM-1-i], "R1 after reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule